// File: doc/BRIEF.md
# DMA Page Register and Address Mapper

This block sits on the byte-wide I/O bus of a legacy eight-channel DMA subsystem. It recognises three address windows. The first is the sixteen registers of the byte-channel controller. The second is the thirty-two address window of the word-channel controller, where each register occupies an even/odd pair. The third is the sixteen page-register ports. For either controller it reports which one is addressed and the register index that controller should decode. It does not hold the controllers themselves.

It stores one 8-bit page register for every channel except channel 4, which is the cascade channel and has none. The page ports do not follow channel order, so the decoder maps each port to its channel explicitly. Each page register can be written and read back through its port.

A separate combinational path forms a physical address from a channel number, the channel's current 16-bit unit address and a unit step. Channels 0–3 move bytes. Their offset wraps inside a 64 KB segment, and the page register supplies address bits 23:16. Channels 5–7 move 16-bit words. Their offset is doubled and wraps inside a 128 KB window, and the page register supplies only bits 23:17, so page bit 0 is dropped. An offset overflow never carries into the page bits.

Top module: `dma_page_mapper`

## Requirements
- R1: After reset every page register is 0, so every page port reads 0 and every channel's physical address has zero page bits.
- R2: A write to a page port stores the data byte in that port's channel, and a read of the port returns it. The port-to-channel map is 0x87→0, 0x83→1, 0x81→2, 0x82→3, 0x8B→5, 0x89→6, 0x8A→7.
- R3: Every other address in 0x80–0x8F is an unmapped page port. It reads 0, and a write to it changes no page register. Any address outside 0x80–0x8F also reads 0.
- R4: An address below 0x10 selects the byte-channel controller (`ctl_sel_o` = 2'b01), with register index equal to address bits 3:0.
- R5: An address in 0xC0–0xDF selects the word-channel controller (`ctl_sel_o` = 2'b10), with register index (address − 0xC0) >> 1.
- R6: Any other address gives `ctl_sel_o` = 2'b00 and index 0. `page_hit_o` is 1 exactly for addresses 0x80–0x8F.
- R7: For channels 0–3, `phys_addr_o` = {page, (cur + step) mod 2^16}.
- R8: For channels 4–7, `phys_addr_o` = {page[7:1], ((cur + step) mod 2^16) << 1}. Bit 0 is therefore 0 and the offset wraps in 128 KB.
- R9: Offset overflow never alters the page bits of `phys_addr_o`. Channel 4 always has page bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 8 | I/O port address |
| io_wr_i | input | 1 | I/O write strobe, sampled on the clock edge |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | Page port read data (0 when unmapped) |
| page_hit_o | output | 1 | Address lies in the page port range |
| ctl_sel_o | output | 2 | Controller select: bit 0 byte controller, bit 1 word controller |
| ctl_idx_o | output | 4 | Register index for the selected controller |
| ch_i | input | 3 | Channel for address formation |
| cur_addr_i | input | 16 | Channel current unit address |
| step_i | input | 16 | Units advanced from the current address |
| phys_addr_o | output | 24 | Physical byte address |

## Verification
Every mapped page port is loaded with a distinct value and read back. A decoder that follows channel order instead of the scrambled map would return another channel's byte. Writes are also aimed at unmapped page ports, and the bench then confirms that all stored pages are unchanged, which catches decoding that only looks at the low bits. Address vectors cross the 64 KB and 128 KB boundaries on byte and word channels. A design that lets the carry reach the page bits, that keeps page bit 0 on word channels, or that fails to double the word offset produces a wrong page or an odd address. The window edges 0x0F/0x10, 0xBF/0xC0 and 0xDF/0xE0 expose off-by-one range checks and a missing halving of the second controller's index.

// File: rtl/dma_map_pkg.sv
package dma_map_pkg;
  localparam int unsigned CH_N      = 8;
  localparam int unsigned CH_W      = 3;
  localparam int unsigned CASCADE_CH = 4;
  localparam logic [3:0]  PAGE_HI   = 4'h8;

  typedef struct packed {
    logic            vld;
    logic [CH_W-1:0] ch;
  } page_map_t;

  // low nibble of a page port -> channel
  function automatic page_map_t page_port_ch(input logic [3:0] lo);
    page_map_t m;
    m.vld = 1'b1;
    unique case (lo)
      4'h7: m.ch = 3'd0;
      4'h3: m.ch = 3'd1;
      4'h1: m.ch = 3'd2;
      4'h2: m.ch = 3'd3;
      4'hB: m.ch = 3'd5;
      4'h9: m.ch = 3'd6;
      4'hA: m.ch = 3'd7;
      default: begin
        m.vld = 1'b0;
        m.ch  = '0;
      end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_map_pkg::*;
#(
  parameter int unsigned IO_AW = 8
) (
  input  logic [IO_AW-1:0] io_addr_i,
  output logic             page_hit_o,
  output logic             page_vld_o,
  output logic [CH_W-1:0]  page_ch_o,
  output logic [1:0]       ctl_sel_o,
  output logic [3:0]       ctl_idx_o
);
  localparam logic [IO_AW-1:0] CTL1_LO = IO_AW'(8'hC0);
  localparam logic [IO_AW-1:0] CTL1_HI = IO_AW'(8'hDF);
  localparam logic [IO_AW-1:0] CTL0_LIM = IO_AW'(8'h10);

  page_map_t pm;
  logic      in_page, in_c0, in_c1;

  always_comb begin
    in_page = (io_addr_i[IO_AW-1:4] == (IO_AW-4)'(PAGE_HI));
    in_c0   = (io_addr_i < CTL0_LIM);
    in_c1   = (io_addr_i >= CTL1_LO) && (io_addr_i <= CTL1_HI);
    pm      = page_port_ch(io_addr_i[3:0]);

    page_hit_o = in_page;
    page_vld_o = in_page & pm.vld;
    page_ch_o  = pm.ch;

    ctl_sel_o = {in_c1, in_c0};
    if (in_c0)      ctl_idx_o = io_addr_i[3:0];
    else if (in_c1) ctl_idx_o = io_addr_i[4:1];
    else            ctl_idx_o = '0;
  end
endmodule

// File: rtl/dma_page_file.sv
module dma_page_file
  import dma_map_pkg::*;
#(
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [PAGE_W-1:0] wdata_i,
  input  logic [CH_W-1:0]   rd_a_ch_i,
  output logic [PAGE_W-1:0] rd_a_o,
  input  logic [CH_W-1:0]   rd_b_ch_i,
  output logic [PAGE_W-1:0] rd_b_o
);
  logic [PAGE_W-1:0] page_q [CH_N];

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    if (c == CASCADE_CH) begin : g_none
      assign page_q[c] = '0;
    end else begin : g_reg
      logic [PAGE_W-1:0] pg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           pg_q <= '0;
        else if (wr_i && wr_ch_i == CH_W'(c))  pg_q <= wdata_i;
      end
      assign page_q[c] = pg_q;
    end
  end

  assign rd_a_o = page_q[rd_a_ch_i];
  assign rd_b_o = page_q[rd_b_ch_i];
endmodule

// File: rtl/dma_addr_former.sv
module dma_addr_former
  import dma_map_pkg::*;
#(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFS_W  = 16,
  localparam int unsigned PHYS_W = PAGE_W + OFS_W
) (
  input  logic [CH_W-1:0]   ch_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFS_W-1:0]  cur_i,
  input  logic [OFS_W-1:0]  step_i,
  output logic [PHYS_W-1:0] phys_o
);
  logic [OFS_W-1:0]  units;
  logic [OFS_W:0]    off;
  logic [PHYS_W-1:0] base;
  logic              word;

  always_comb begin
    word  = ch_i[CH_W-1];
    units = cur_i + step_i;           // wraps modulo the segment
    if (word) begin
      off  = {units, 1'b0};
      base = {page_i[PAGE_W-1:1], {(OFS_W+1){1'b0}}};
    end else begin
      off  = {1'b0, units};
      base = {page_i, {OFS_W{1'b0}}};
    end
    phys_o = base | {{(PAGE_W-1){1'b0}}, off};
  end
endmodule

// File: rtl/dma_page_mapper.sv
module dma_page_mapper
  import dma_map_pkg::*;
#(
  parameter int unsigned IO_AW  = 8,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFS_W  = 16,
  localparam int unsigned PHYS_W = PAGE_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic              io_wr_i,
  input  logic [PAGE_W-1:0] io_wdata_i,
  output logic [PAGE_W-1:0] io_rdata_o,
  output logic              page_hit_o,
  output logic [1:0]        ctl_sel_o,
  output logic [3:0]        ctl_idx_o,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [OFS_W-1:0]  cur_addr_i,
  input  logic [OFS_W-1:0]  step_i,
  output logic [PHYS_W-1:0] phys_addr_o
);
  logic              page_vld;
  logic [CH_W-1:0]   page_ch;
  logic [PAGE_W-1:0] port_page, chan_page;

  dma_port_decode #(.IO_AW(IO_AW)) u_dec (
    .io_addr_i (io_addr_i),
    .page_hit_o(page_hit_o),
    .page_vld_o(page_vld),
    .page_ch_o (page_ch),
    .ctl_sel_o (ctl_sel_o),
    .ctl_idx_o (ctl_idx_o)
  );

  dma_page_file #(.PAGE_W(PAGE_W)) u_pages (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (io_wr_i & page_vld),
    .wr_ch_i  (page_ch),
    .wdata_i  (io_wdata_i),
    .rd_a_ch_i(page_ch),
    .rd_a_o   (port_page),
    .rd_b_ch_i(ch_i),
    .rd_b_o   (chan_page)
  );

  assign io_rdata_o = page_vld ? port_page : '0;

  dma_addr_former #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_addr (
    .ch_i  (ch_i),
    .page_i(chan_page),
    .cur_i (cur_addr_i),
    .step_i(step_i),
    .phys_o(phys_addr_o)
  );
endmodule

// File: rtl/dma_page_mapper_chk.sv
module dma_page_mapper_chk #(
  parameter int unsigned IO_AW  = 8,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFS_W  = 16,
  localparam int unsigned PHYS_W = PAGE_W + OFS_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IO_AW-1:0]  io_addr_i,
  input logic              io_wr_i,
  input logic [PAGE_W-1:0] io_wdata_i,
  input logic [PAGE_W-1:0] io_rdata_o,
  input logic              page_hit_o,
  input logic [1:0]        ctl_sel_o,
  input logic [2:0]        ch_i,
  input logic [OFS_W-1:0]  cur_addr_i,
  input logic [OFS_W-1:0]  step_i,
  input logic [PHYS_W-1:0] phys_addr_o
);
  logic [OFS_W-1:0] units;
  assign units = cur_addr_i + step_i;

  p_page_wr_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(io_wr_i && io_addr_i == IO_AW'(8'h87)) && io_addr_i == IO_AW'(8'h87))
      |-> io_rdata_o == $past(io_wdata_i));

  p_unmapped_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_addr_i == IO_AW'(8'h80) || !page_hit_o) |-> io_rdata_o == '0);

  p_ctl_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctl_sel_o) && !(page_hit_o && ctl_sel_o != 2'b00));

  p_ctl0_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_sel_o[0] |-> io_addr_i < IO_AW'(8'h10));

  p_byte_ofs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch_i[2] |-> phys_addr_o[OFS_W-1:0] == units);

  p_word_even_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_i[2] |-> (!phys_addr_o[0] && phys_addr_o[OFS_W:1] == units));

  p_no_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(ch_i) && !$past(io_wr_i) && !ch_i[2]) |-> $stable(phys_addr_o[PHYS_W-1:OFS_W]));

  p_cascade_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_i == 3'd4) |-> phys_addr_o[PHYS_W-1:OFS_W+1] == '0);
endmodule

bind dma_page_mapper dma_page_mapper_chk #(
  .IO_AW(IO_AW), .PAGE_W(PAGE_W), .OFS_W(OFS_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_addr_i  (io_addr_i),
  .io_wr_i    (io_wr_i),
  .io_wdata_i (io_wdata_i),
  .io_rdata_o (io_rdata_o),
  .page_hit_o (page_hit_o),
  .ctl_sel_o  (ctl_sel_o),
  .ch_i       (ch_i),
  .cur_addr_i (cur_addr_i),
  .step_i     (step_i),
  .phys_addr_o(phys_addr_o)
);

// File: tb/dma_page_mapper_tb_top.sv
module dma_page_mapper_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  io_addr_i = '0;
  logic        io_wr_i = 1'b0;
  logic [7:0]  io_wdata_i = '0;
  logic [7:0]  io_rdata_o;
  logic        page_hit_o;
  logic [1:0]  ctl_sel_o;
  logic [3:0]  ctl_idx_o;
  logic [2:0]  ch_i = '0;
  logic [15:0] cur_addr_i = '0;
  logic [15:0] step_i = '0;
  logic [23:0] phys_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  dma_page_mapper dut_i (.*);

  // {ch, cur, step, expected phys}
  localparam int NV = 11;
  localparam logic [58:0] VEC [NV] = '{
    {3'd0, 16'h1000, 16'h0000, 24'h121000},
    {3'd1, 16'hFFFF, 16'h0001, 24'h340000},
    {3'd2, 16'h8000, 16'h9000, 24'h561000},
    {3'd3, 16'hABCD, 16'h0000, 24'h78ABCD},
    {3'd5, 16'h1234, 16'h0000, 24'h9A2468},
    {3'd5, 16'hFFFF, 16'h0000, 24'h9BFFFE},
    {3'd6, 16'hFFFF, 16'h0001, 24'hAC0000},
    {3'd7, 16'h8000, 16'h0000, 24'hDF0000},
    {3'd7, 16'hFFFF, 16'h0002, 24'hDE0002},
    {3'd4, 16'h0100, 16'h0000, 24'h000200},
    {3'd0, 16'h0000, 16'hFFFF, 24'h12FFFF}
  };

  localparam logic [7:0] PPORT [7] = '{8'h87, 8'h83, 8'h81, 8'h82, 8'h8B, 8'h89, 8'h8A};
  localparam logic [7:0] PVAL  [7] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9B, 8'hAC, 8'hDF};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
    @(negedge clk_i);
    io_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk_i);
    io_addr_i = a;
    #1;
  endtask

  task automatic dec(input logic [7:0] a, input logic [1:0] sel, input logic [3:0] idx,
                     input logic hit, input string req);
    rd(a);
    chk(req, {28'd0, ctl_sel_o, 2'b00} | {31'd0, 1'b0}, {28'd0, sel, 2'b00});
    chk(req, {28'd0, ctl_idx_o}, {28'd0, idx});
    chk(req, {31'd0, page_hit_o}, {31'd0, hit});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    for (int i = 0; i < 7; i++) begin
      rd(PPORT[i]);
      chk("R1 page reset", {24'd0, io_rdata_o}, 32'd0);
    end
    ch_i = 3'd0; cur_addr_i = 16'h0055; #1;
    chk("R1 phys reset", {8'd0, phys_addr_o}, 32'h00000055);

    // R2 load every page port and read it back
    for (int i = 0; i < 7; i++) io_write(PPORT[i], PVAL[i]);
    for (int i = 0; i < 7; i++) begin
      rd(PPORT[i]);
      chk("R2 page readback", {24'd0, io_rdata_o}, {24'd0, PVAL[i]});
    end

    // R3 unmapped ports read 0, writes ignored
    io_write(8'h80, 8'hFF);
    io_write(8'h84, 8'hEE);
    io_write(8'h88, 8'hDD);
    io_write(8'h8F, 8'hCC);
    io_write(8'h07, 8'hBB);
    rd(8'h80); chk("R3 read 0x80", {24'd0, io_rdata_o}, 32'd0);
    rd(8'h88); chk("R3 read 0x88", {24'd0, io_rdata_o}, 32'd0);
    rd(8'h8F); chk("R3 read 0x8F", {24'd0, io_rdata_o}, 32'd0);
    rd(8'h07); chk("R3 read 0x07", {24'd0, io_rdata_o}, 32'd0);
    for (int i = 0; i < 7; i++) begin
      rd(PPORT[i]);
      chk("R3 pages untouched", {24'd0, io_rdata_o}, {24'd0, PVAL[i]});
    end

    // R7 R8 R9 address vectors
    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      ch_i = VEC[v][58:56]; cur_addr_i = VEC[v][55:40]; step_i = VEC[v][39:24];
      #1;
      chk(VEC[v][58] ? "R8 R9 word phys" : "R7 R9 byte phys",
          {8'd0, phys_addr_o}, {8'd0, VEC[v][23:0]});
    end

    // R4 R5 R6 decode windows
    dec(8'h00, 2'b01, 4'h0, 1'b0, "R4 0x00");
    dec(8'h0F, 2'b01, 4'hF, 1'b0, "R4 0x0F");
    dec(8'h10, 2'b00, 4'h0, 1'b0, "R6 0x10");
    dec(8'hBF, 2'b00, 4'h0, 1'b0, "R6 0xBF");
    dec(8'hC0, 2'b10, 4'h0, 1'b0, "R5 0xC0");
    dec(8'hC3, 2'b10, 4'h1, 1'b0, "R5 0xC3");
    dec(8'hD6, 2'b10, 4'hB, 1'b0, "R5 0xD6");
    dec(8'hDF, 2'b10, 4'hF, 1'b0, "R5 0xDF");
    dec(8'hE0, 2'b00, 4'h0, 1'b0, "R6 0xE0");
    dec(8'h87, 2'b00, 4'h0, 1'b1, "R6 0x87");
    dec(8'h8F, 2'b00, 4'h0, 1'b1, "R6 0x8F");
    dec(8'h90, 2'b00, 4'h0, 1'b0, "R6 0x90");

    // R1 reset again clears pages
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    rd(8'h8A); chk("R1 page after reset", {24'd0, io_rdata_o}, 32'd0);
    ch_i = 3'd7; cur_addr_i = 16'h0001; step_i = '0; #1;
    chk("R1 R8 phys after reset", {8'd0, phys_addr_o}, 32'h00000002);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule